// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit and register set of a small accumulator machine. It runs each instruction through a fixed series of subcycles: fetch, an optional indirect-address step, execute, and an optional interrupt step. All memory traffic passes through the memory address register (MAR) and the memory buffer register (MBR). The block reaches memory through a single port: one address, one write-data bus, separate read and write strobes, and a `mem_ready` reply. A strobe stays raised until the memory answers.

An instruction is one 16-bit word. Bits [15:12] carry the opcode, bit 11 marks an indirect operand, and bits [10:0] hold an address. An external pulse arms the interrupt-enable flag. A pending request is taken only at the end of an execute step. When it is taken, the program counter is stored at a fixed save location and control moves to a fixed handler address.

Top module: `icyc_seq`

## Requirements
- R1: Fetch takes one cycle to copy PC into MAR, then reads at MAR until ready. The returned word goes into MBR, and on the following cycle MBR is copied into IR.
- R2: PC increases by exactly one, modulo 2^ADDR_W, in the cycle where the fetch read completes. No other fetch cycle changes PC.
- R3: When bit 11 of the fetched word is 1, an extra step loads MAR from MBR[10:0] and reads at that address. The returned word replaces MBR, and its low 11 bits become the operand address for execute.
- R4: Execute first loads MAR with the operand address. Opcode 1 (load) reads the operand into ACC. Opcode 2 (store) copies ACC into MBR and writes it to MAR. Opcode 3 (add) reads the operand and adds it to ACC. Opcode 4 (jump) loads PC with the operand address. Every other opcode does nothing.
- R5: The interrupt step loads MBR with PC (zero-extended) and MAR with SAVE_ADDR, then writes MBR to memory. When that write completes, PC becomes HANDLER_ADDR and a fetch follows.
- R6: A request on `irq` is taken only in the last cycle of execute, and only while `ie_q` is 1. Taking it clears `ie_q`. At any other time, a pulse on `ie_set` sets `ie_q`.
- R7: `mem_rd` and `mem_wr` are never high together. While a strobe is high and `mem_ready` is low, the strobe, `mem_addr` and `mem_wdata` all stay unchanged.
- R8: `flag_z` and `flag_c` change only when an add completes. `flag_c` takes the carry out of ACC + operand, and `flag_z` is set when the truncated sum is zero.
- R9: While `rst_n` is low, PC holds RESET_PC, MAR, MBR, IR, ACC, both flags and `ie_q` are zero, and no strobe is high. After reset is released, fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | WORD_W | Read data returned by memory |
| mem_ready | input | 1 | Memory has completed the access that is currently strobed |
| irq | input | 1 | Interrupt request level |
| ie_set | input | 1 | Pulse that sets the interrupt-enable flag |
| mem_addr | output | ADDR_W | Memory address, taken from MAR |
| mem_wdata | output | WORD_W | Write data, taken from MBR |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc | output | ADDR_W | Program counter |
| mar | output | ADDR_W | Memory address register |
| mbr | output | WORD_W | Memory buffer register |
| ir | output | WORD_W | Instruction register |
| acc | output | WORD_W | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| ie_q | output | 1 | Interrupt-enable flag |

## Verification
The hold properties assume that memory raises `mem_ready` only while a strobe is high, and that it may stall for any number of cycles. The bench's memory model follows this: it answers only strobed accesses, and it varies the wait between zero and two cycles so that back-to-back and stalled completions both occur. The interrupt properties assume that `irq` is a level that can be high in any cycle. The stimulus therefore holds `irq` high for long windows and pulses `ie_set` only now and then, so that requests arrive both while enabled and while masked, at many different points of the instruction cycle.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OPC_LOAD  = 1;
  localparam int OPC_STORE = 2;
  localparam int OPC_ADD   = 3;
  localparam int OPC_JUMP  = 4;

  typedef enum logic [3:0] {
    ST_FADR,   // PC -> MAR
    ST_FRD,    // read instruction word
    ST_DEC,    // MBR -> IR, pick indirect or execute
    ST_IADR,   // address field -> MAR
    ST_IRD,    // read operand address
    ST_EX,     // operand address -> MAR, register-only work
    ST_EXMEM,  // operand read or write
    ST_INT,    // PC -> MBR, save address -> MAR
    ST_SAVE    // write return address
  } seq_st_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_addr;
    logic mar_save;
    logic mbr_mem;
    logic mbr_acc;
    logic mbr_pc;
    logic ir_ld;
    logic pc_inc;
    logic pc_addr;
    logic pc_vec;
    logic acc_ld;
    logic acc_add;
    logic rd;
    logic wr;
    logic end_ex;
    logic take_int;
  } seq_ctl_t;

endpackage

// File: rtl/icyc_fsm.sv
module icyc_fsm
  import icyc_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] op,
  input  logic             ind,
  input  logic             mem_ready,
  input  logic             irq,
  input  logic             ie_q,
  output seq_ctl_t         ctl
);

  localparam logic [OPC_W-1:0] K_LOAD  = OPC_W'(OPC_LOAD);
  localparam logic [OPC_W-1:0] K_STORE = OPC_W'(OPC_STORE);
  localparam logic [OPC_W-1:0] K_ADD   = OPC_W'(OPC_ADD);
  localparam logic [OPC_W-1:0] K_JUMP  = OPC_W'(OPC_JUMP);

  seq_st_e st, st_nxt;
  logic    finish;

  always_comb begin
    ctl    = '0;
    st_nxt = st;
    finish = 1'b0;
    unique case (st)
      ST_FADR: begin
        ctl.mar_pc = 1'b1;
        st_nxt     = ST_FRD;
      end
      ST_FRD: begin
        ctl.rd = 1'b1;
        if (mem_ready) begin
          ctl.mbr_mem = 1'b1;
          ctl.pc_inc  = 1'b1;
          st_nxt      = ST_DEC;
        end
      end
      ST_DEC: begin
        ctl.ir_ld = 1'b1;
        st_nxt    = ind ? ST_IADR : ST_EX;
      end
      ST_IADR: begin
        ctl.mar_addr = 1'b1;
        st_nxt       = ST_IRD;
      end
      ST_IRD: begin
        ctl.rd = 1'b1;
        if (mem_ready) begin
          ctl.mbr_mem = 1'b1;
          st_nxt      = ST_EX;
        end
      end
      ST_EX: begin
        ctl.mar_addr = 1'b1;
        if (op == K_JUMP) begin
          ctl.pc_addr = 1'b1;
          finish      = 1'b1;
        end else if (op == K_STORE) begin
          ctl.mbr_acc = 1'b1;
          st_nxt      = ST_EXMEM;
        end else if (op == K_LOAD || op == K_ADD) begin
          st_nxt = ST_EXMEM;
        end else begin
          finish = 1'b1;
        end
      end
      ST_EXMEM: begin
        ctl.wr = (op == K_STORE);
        ctl.rd = (op != K_STORE);
        if (mem_ready) begin
          ctl.acc_ld  = (op == K_LOAD);
          ctl.acc_add = (op == K_ADD);
          finish      = 1'b1;
        end
      end
      ST_INT: begin
        ctl.mbr_pc   = 1'b1;
        ctl.mar_save = 1'b1;
        st_nxt       = ST_SAVE;
      end
      ST_SAVE: begin
        ctl.wr = 1'b1;
        if (mem_ready) begin
          ctl.pc_vec = 1'b1;
          st_nxt     = ST_FADR;
        end
      end
      default: st_nxt = ST_FADR;
    endcase
    if (finish) begin
      ctl.end_ex   = 1'b1;
      ctl.take_int = irq && ie_q;
      st_nxt       = (irq && ie_q) ? ST_INT : ST_FADR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_FADR;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
  import icyc_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 11,
  parameter int RESET_PC     = 0,
  parameter int SAVE_ADDR    = 'h7F0,
  parameter int HANDLER_ADDR = 'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ctl_t          ctl,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              ie_set,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mbr,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] acc,
  output logic              flag_z,
  output logic              flag_c,
  output logic              ie_q
);

  localparam logic [ADDR_W-1:0] K_SAVE = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] K_VEC  = ADDR_W'(HANDLER_ADDR);
  localparam logic [ADDR_W-1:0] K_RST  = ADDR_W'(RESET_PC);

  // sum with carry in the top bit
  function automatic logic [WORD_W:0] add_wc(input logic [WORD_W-1:0] a,
                                             input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  logic [WORD_W:0] sum_c;
  assign sum_c = add_wc(acc, mem_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= K_RST;
      mar    <= '0;
      mbr    <= '0;
      ir     <= '0;
      acc    <= '0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (ctl.mar_pc)        mar <= pc;
      else if (ctl.mar_addr) mar <= addr_of(mbr);
      else if (ctl.mar_save) mar <= K_SAVE;

      if (ctl.mbr_mem)      mbr <= mem_rdata;
      else if (ctl.mbr_acc) mbr <= acc;
      else if (ctl.mbr_pc)  mbr <= WORD_W'(pc);

      if (ctl.ir_ld) ir <= mbr;

      if (ctl.pc_inc)       pc <= pc + 1'b1;
      else if (ctl.pc_addr) pc <= addr_of(mbr);
      else if (ctl.pc_vec)  pc <= K_VEC;

      if (ctl.acc_ld) acc <= mem_rdata;
      else if (ctl.acc_add) begin
        acc    <= sum_c[WORD_W-1:0];
        flag_c <= sum_c[WORD_W];
        flag_z <= (sum_c[WORD_W-1:0] == '0);
      end

      if (ctl.take_int) ie_q <= 1'b0;
      else if (ie_set)  ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int OPC_W        = 4,
  parameter int ADDR_W       = WORD_W - OPC_W - 1,
  parameter int RESET_PC     = 0,
  parameter int SAVE_ADDR    = 'h7F0,
  parameter int HANDLER_ADDR = 'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              irq,
  input  logic              ie_set,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mbr,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] acc,
  output logic              flag_z,
  output logic              flag_c,
  output logic              ie_q
);

  localparam int IND_BIT = ADDR_W;

  seq_ctl_t ctl;

  // named events for the checker
  logic fetch_done;
  logic add_done;
  logic int_enter;
  logic save_done;

  icyc_fsm #(.OPC_W(OPC_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (ir[WORD_W-1 -: OPC_W]),
    .ind       (mbr[IND_BIT]),
    .mem_ready (mem_ready),
    .irq       (irq),
    .ie_q      (ie_q),
    .ctl       (ctl)
  );

  icyc_regs #(
    .WORD_W       (WORD_W),
    .ADDR_W       (ADDR_W),
    .RESET_PC     (RESET_PC),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .ie_set    (ie_set),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .ir        (ir),
    .acc       (acc),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .ie_q      (ie_q)
  );

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign mem_rd     = ctl.rd;
  assign mem_wr     = ctl.wr;
  assign fetch_done = ctl.pc_inc;
  assign add_done   = ctl.acc_add;
  assign int_enter  = ctl.take_int;
  assign save_done  = ctl.pc_vec;

endmodule

// File: rtl/icyc_seq_chk.sv
module icyc_seq_chk #(
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 11,
  parameter int SAVE_ADDR    = 'h7F0,
  parameter int HANDLER_ADDR = 'h040
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mar,
  input logic [WORD_W-1:0] mbr,
  input logic              flag_z,
  input logic              flag_c,
  input logic              ie_q,
  input logic              fetch_done,
  input logic              add_done,
  input logic              int_enter,
  input logic              save_done
);

  p_excl_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_hold_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  p_hold_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (pc == $past(pc) + 1'b1));

  p_save_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_enter |-> ##2 (mar == ADDR_W'(SAVE_ADDR) && mbr == WORD_W'($past(pc)) && mem_wr));

  p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    save_done |=> (pc == ADDR_W'(HANDLER_ADDR)));

  p_ie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_enter |=> !ie_q);

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !add_done |=> $stable({flag_z, flag_c}));

endmodule

bind icyc_seq icyc_seq_chk #(
  .WORD_W       (WORD_W),
  .ADDR_W       (ADDR_W),
  .SAVE_ADDR    (SAVE_ADDR),
  .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .pc         (pc),
  .mar        (mar),
  .mbr        (mbr),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .ie_q       (ie_q),
  .fetch_done (fetch_done),
  .add_done   (add_done),
  .int_enter  (int_enter),
  .save_done  (save_done)
);

// File: tb/icyc_seq_tb.sv
module icyc_seq_tb;

  localparam int W    = 16;
  localparam int A    = 11;
  localparam int SAVE = 'h7F0;
  localparam int VEC  = 'h040;
  localparam int RUN  = 3000;
  localparam int WDOG = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;
  logic         irq = 1'b0;
  logic         ie_set = 1'b0;
  logic [A-1:0] mem_addr, pc, mar;
  logic [W-1:0] mem_wdata, mbr, ir, acc;
  logic         mem_rd, mem_wr, flag_z, flag_c, ie_q;

  always #4 clk = ~clk;

  icyc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq(irq), .ie_set(ie_set), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .mar(mar), .mbr(mbr), .ir(ir),
    .acc(acc), .flag_z(flag_z), .flag_c(flag_c), .ie_q(ie_q)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] mem [0:2047];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int           step = 0;        // 0 fetch-addr .. 9 save-write
  logic [A-1:0] m_pc = '0, m_mar = '0;
  logic [W-1:0] m_mbr = '0, m_ir = '0, m_acc = '0;
  logic         m_z = 0, m_c = 0, m_ie = 0;
  logic [W-1:0] m_saved = '0;
  int           n_int = 0;
  bit           seen_edge = 0;

  function automatic int opc(input logic [W-1:0] w);
    return int'(w[15:12]);
  endfunction

  always @(posedge clk) begin
    automatic bit wrap = 0;
    automatic int s;
    automatic logic [W:0] t;
    seen_edge <= 1;
    if (!rst_n) begin
      step = 0; m_pc = '0; m_mar = '0; m_mbr = '0; m_ir = '0; m_acc = '0;
      m_z = 0; m_c = 0; m_ie = 0;
    end else begin
      s = step;
      case (s)
        0: begin m_mar = m_pc; step = 1; end
        1: if (mem_ready) begin m_mbr = mem_rdata; m_pc = m_pc + 1; step = 2; end
        2: begin m_ir = m_mbr; step = m_mbr[11] ? 3 : 5; end
        3: begin m_mar = m_mbr[10:0]; step = 4; end
        4: if (mem_ready) begin m_mbr = mem_rdata; step = 5; end
        5: begin
          m_mar = m_mbr[10:0];
          case (opc(m_ir))
            4: begin m_pc = m_mbr[10:0]; wrap = 1; end
            2: begin m_mbr = m_acc; step = 6; end
            1, 3: step = 6;
            default: wrap = 1;
          endcase
        end
        6: if (mem_ready) begin
          if (opc(m_ir) == 1) m_acc = mem_rdata;
          if (opc(m_ir) == 3) begin
            t = {1'b0, m_acc} + {1'b0, mem_rdata};
            m_acc = t[W-1:0]; m_c = t[W]; m_z = (t[W-1:0] == 0);
          end
          wrap = 1;
        end
        8: begin m_mbr = {5'b0, m_pc}; m_saved = m_mbr; m_mar = A'(SAVE); step = 9; end
        9: if (mem_ready) begin m_pc = A'(VEC); step = 0; end
        default: step = 0;
      endcase
      if (wrap) begin
        if (irq && m_ie) begin step = 8; m_ie = 0; n_int++; end
        else begin step = 0; if (ie_set) m_ie = 1; end
      end else if (ie_set) m_ie = 1;
    end
  end

  // ---------------- memory and stimulus ----------------
  int cyc = 0, wcnt = 0, lat = 0;

  function automatic logic [W-1:0] ins(input int op, input bit ind, input int adr);
    return {op[3:0], ind, adr[10:0]};
  endfunction

  always @(negedge clk) begin
    automatic string rq;
    automatic bit exp_rd, exp_wr;
    if (seen_edge) begin
      exp_rd = (step == 1) || (step == 4) || (step == 6 && opc(m_ir) != 2);
      exp_wr = (step == 6 && opc(m_ir) == 2) || (step == 9);
      rq = rst_n ? "" : "R9 ";
      chk({rq, "R1 ir"},    32'(ir),  32'(m_ir));
      chk({rq, "R2 pc"},    32'(pc),  32'(m_pc));
      chk({rq, "R3 mar"},   32'(mar), 32'(m_mar));
      chk({rq, "R5 mbr"},   32'(mbr), 32'(m_mbr));
      chk({rq, "R4 acc"},   32'(acc), 32'(m_acc));
      chk({rq, "R8 flags"}, {30'b0, flag_z, flag_c}, {30'b0, m_z, m_c});
      chk({rq, "R6 ie"},    32'(ie_q), 32'(m_ie));
      chk({rq, "R7 strobes"}, {30'b0, mem_rd, mem_wr}, {30'b0, exp_rd, exp_wr});
      chk({rq, "R7 addr"},  32'(mem_addr),  32'(m_mar));
      chk({rq, "R7 wdata"}, 32'(mem_wdata), 32'(m_mbr));
    end
    // memory response, wait of 0..2 cycles
    mem_rdata = mem[mem_addr];
    mem_ready = 1'b0;
    if (mem_rd || mem_wr) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        wcnt = 0;
        lat = (lat + 1) % 3;
        if (mem_wr) mem[mem_addr] = mem_wdata;
      end else wcnt++;
    end else wcnt = 0;
    irq    = ((cyc / 40) % 3) == 0;
    ie_set = (cyc % 97) == 5;
    cyc++;
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[0] = ins(1, 0, 'h100);   // load 5
    mem[1] = ins(3, 1, 'h101);   // add indirect -> 0xFFFF
    mem[2] = ins(2, 0, 'h103);   // store 4
    mem[3] = ins(3, 0, 'h104);   // add 0xFFFC -> 0, carry
    mem[4] = ins(1, 0, 'h100);   // load 5
    mem[5] = ins(0, 0, 'h000);   // no-op opcode
    mem[6] = ins(2, 1, 'h105);   // store indirect -> 0x106
    mem[7] = ins(4, 0, 'h000);   // jump 0
    mem['h100] = 16'h0005;
    mem['h101] = 16'h0102;
    mem['h102] = 16'hFFFF;
    mem['h104] = 16'hFFFC;
    mem['h105] = 16'h0106;
    mem[VEC]     = ins(3, 0, 'h100);
    mem[VEC + 1] = ins(4, 0, 'h000);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (RUN) @(negedge clk);
    #1;
    chk("R4 store result", 32'(mem['h103]), 32'h0004);
    chk("R3 indirect store", 32'(mem['h106]), 32'h0005);
    chk("R5 saved return", 32'(mem[SAVE]), 32'(m_saved));
    chk("R6 interrupts taken", 32'(n_int > 1), 32'd1);
    finish_run();
  end

  initial begin
    #(WDOG * 8);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule